// File: doc/BRIEF.md
# Shadow-Registered PWM Generator

This block drives one pulse-width-modulated output pin from three programmable words: a control word with a clock prescale value, a duty word, and a period word. A prescaler divides the module clock into a PWM tick. A 10-bit counter counts those ticks across one PWM cycle. The output is high for the first part of each cycle and low for the rest.

Software writes into a programmed register set through a simple write strobe, a select and a data word. The generator never runs from those registers directly. Its working copies of all three registers are refreshed together, and only when the tick counter wraps at the end of a cycle. Every PWM cycle therefore runs on one consistent set of values, even when a write lands in the middle of a cycle.

Three corner cases have their own fixed behaviour. A forced-full flag holds the output high. A duty of zero without that flag holds the output low. A period of zero holds the output high in every other case.

Top module: `pwm_shadow_gen`

## Requirements
- R1: After the synchronous active-low reset, every programmed and working value is 0 and `pwm_out` is low.
- R2: A write with `wr_en` high stores `wr_data` into the register picked by `wr_sel`. Select 0 is control, with the prescale value in bits 5:0. Select 1 is duty, with the duty count in bits 9:0 and the forced-full flag in bit 10. Select 2 is period, with the period value in bits 9:0. Select 3 and all other data bits are ignored.
- R3: The PWM tick fires once every N+1 module clocks, where N is the working prescale value (0 to 63). This gives 1 to 64 clocks per tick.
- R4: For a period value P, one PWM cycle lasts P+1 ticks. The tick counter runs 0..P and never exceeds P.
- R5: With the forced-full flag clear, `pwm_out` is high during the first D ticks of each cycle and low for the remaining ticks, where D is the duty count. The output rises only at the start of a cycle.
- R6: With the forced-full flag set, `pwm_out` is high for the whole cycle, whatever the duty count.
- R7: With the forced-full flag clear and a duty count of 0, `pwm_out` stays low for any period value.
- R8: With a period value of 0, `pwm_out` stays high unless the case of R7 applies.
- R9: A duty count greater than or equal to P+1 keeps `pwm_out` high for the whole cycle.
- R10: Programmed values reach the working copies only on the tick that ends a cycle. At that tick all three are copied together. A write during a cycle has no effect on the output before the next cycle starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 control, 1 duty, 2 period, 3 unused |
| wr_data | input | 32 | Write data |
| pwm_out | output | 1 | PWM output pin |

## Verification
The bench targets writes that land mid-cycle. A design that bypassed the working copies would change its pulse width inside the current cycle. It also sets duty to zero on a non-zero period and then on a zero period; a wrong priority would show a stuck-high output instead of a steady low. It sets the forced-full flag with a small duty value and picks duties beyond the period, where a design that compared counts the wrong way would drop low partway through. The prescale extremes of 1 and 64 clocks per tick catch off-by-one errors in the divider and in the wrap tick, because they move every edge of the waveform.

// File: rtl/pwm_pkg.sv
// pwm_pkg: widths, register selects and the configuration record shared by
// the PWM generator and its checker. Assumes a 32-bit write data path.
package pwm_pkg;

    parameter int DATA_W = 32;   // write data width
    parameter int PRE_W  = 6;    // prescale field width (1..64 clocks per tick)
    parameter int CNT_W  = 10;   // tick counter, duty and period width
    parameter int SEL_W  = 2;    // register select width

    localparam int FULL_BIT = CNT_W;  // forced-full flag sits just above duty

    localparam logic [SEL_W-1:0] SEL_CTRL   = 2'd0;
    localparam logic [SEL_W-1:0] SEL_DUTY   = 2'd1;
    localparam logic [SEL_W-1:0] SEL_PERIOD = 2'd2;

    typedef struct packed {
        logic [PRE_W-1:0] prescale;
        logic             full;
        logic [CNT_W-1:0] duty;
        logic [CNT_W-1:0] period;
    } pwm_cfg_t;

    localparam pwm_cfg_t CFG_RESET = '{prescale: '0, full: 1'b0, duty: '0, period: '0};

endpackage

// File: rtl/pwm_regfile.sv
// pwm_regfile: programmed register set written from the host side.
// Assumes one write per clock; unused select codes and unused data bits
// are dropped. No read path is provided.
module pwm_regfile
    import pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output pwm_cfg_t          prog
);

    pwm_cfg_t prog_q;

    // Capture writes into the field picked by the select
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_q <= CFG_RESET;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_CTRL: prog_q.prescale <= wr_data[PRE_W-1:0];
                SEL_DUTY: begin
                    prog_q.duty <= wr_data[CNT_W-1:0];
                    prog_q.full <= wr_data[FULL_BIT];
                end
                SEL_PERIOD: prog_q.period <= wr_data[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    assign prog = prog_q;

endmodule

// File: rtl/pwm_prescaler.sv
// pwm_prescaler: divides the module clock into a one-clock tick pulse that
// fires every div+1 clocks. Assumes div only changes on a tick, so the
// divider count is at zero whenever a new divide value appears.
module pwm_prescaler
    import pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PRE_W-1:0] div,
    output logic             tick
);

    logic [PRE_W-1:0] div_cnt;

    assign tick = (div_cnt == div);

    // Count clocks between ticks, restarting on each tick
    always_ff @(posedge clk) begin
        if (!rst_n || tick) begin
            div_cnt <= '0;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/pwm_core.sv
// pwm_core: working copies of the configuration, the tick counter and the
// output decode. The working copies reload from the programmed set only on
// the tick that ends a cycle. The output is decoded from flops only.
module pwm_core
    import pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  pwm_cfg_t         prog,
    output pwm_cfg_t         work,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap,
    output logic             pwm_out
);

    pwm_cfg_t         work_q;
    logic [CNT_W-1:0] cnt_q;

    assign wrap = tick && (cnt_q == work_q.period);

    // Advance the tick counter and restart it at the end of the cycle
    always_ff @(posedge clk) begin
        if (!rst_n || wrap) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Copy the whole programmed set into the working copies at the cycle end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work_q <= CFG_RESET;
        end else if (wrap) begin
            work_q <= prog;
        end
    end

    // Drive the pin high for the leading duty ticks or when forced full
    always_comb begin
        pwm_out = work_q.full || (cnt_q < work_q.duty);
    end

    assign work = work_q;
    assign cnt  = cnt_q;

endmodule

// File: rtl/pwm_shadow_gen.sv
// pwm_shadow_gen: single-channel PWM generator with a prescaler, a tick
// counter and shadowed configuration. Assumes a synchronous active-low
// reset and a host that writes one register per clock.
module pwm_shadow_gen
    import pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic              pwm_out
);

    pwm_cfg_t         prog_w;
    pwm_cfg_t         work_w;
    logic             tick_w;
    logic             wrap_w;
    logic [CNT_W-1:0] cnt_w;

    pwm_regfile u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .prog    (prog_w)
    );

    pwm_prescaler u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .div   (work_w.prescale),
        .tick  (tick_w)
    );

    pwm_core u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_w),
        .prog    (prog_w),
        .work    (work_w),
        .cnt     (cnt_w),
        .wrap    (wrap_w),
        .pwm_out (pwm_out)
    );

endmodule

// File: rtl/pwm_shadow_gen_chk.sv
// pwm_shadow_gen_chk: temporal checks on the generator, bound to every
// instance of pwm_shadow_gen. It observes internal nets only and drives none.
module pwm_shadow_gen_chk
    import pwm_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             wrap,
    input logic [CNT_W-1:0] cnt,
    input pwm_cfg_t         work,
    input logic             pwm_out
);

    logic [PRE_W-1:0] gap;

    // Count clocks since the previous tick, independently of the prescaler
    always_ff @(posedge clk) begin
        if (!rst_n || tick) begin
            gap <= '0;
        end else begin
            gap <= gap + 1'b1;
        end
    end

    // R1: the first clock out of reset leaves the output low
    a_r1_low_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !pwm_out);

    // R3: ticks are spaced exactly prescale+1 clocks apart
    a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (gap == work.prescale));

    // R4: the tick counter stays within the working period
    a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= work.period);

    // R5: the output only rises as a new cycle begins
    a_r5_rise_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_out) |-> $past(wrap));

    // R10: working copies hold steady except across a wrap
    a_r10_shadow_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(work));

endmodule

bind pwm_shadow_gen pwm_shadow_gen_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick_w),
    .wrap    (wrap_w),
    .cnt     (cnt_w),
    .work    (work_w),
    .pwm_out (pwm_out)
);

// File: tb/pwm_shadow_gen_tb.sv
// pwm_shadow_gen_tb: behavioural reference model compared with the output
// on every clock, plus directed checks for reset and the corner cases.
module pwm_shadow_gen_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = 32'd0;
    logic        pwm_out;

    int    checks = 0;
    int    fails  = 0;
    bit    running = 1'b0;
    bit    done = 1'b0;
    string phase = "R1";

    // reference model state
    int m_pre, m_duty, m_per, w_pre, w_duty, w_per, m_pc, m_cnt;
    bit m_full, w_full;

    pwm_shadow_gen u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .pwm_out (pwm_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model: programmed values, working values and counters
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pre = 0; m_duty = 0; m_per = 0; m_full = 0;
            w_pre = 0; w_duty = 0; w_per = 0; w_full = 0;
            m_pc = 0; m_cnt = 0;
        end else begin
            bit t, w;
            t = (m_pc == w_pre);
            w = t && (m_cnt == w_per);
            m_pc = t ? 0 : m_pc + 1;
            if (w) begin
                m_cnt = 0;
                w_pre = m_pre; w_duty = m_duty; w_per = m_per; w_full = m_full;
            end else if (t) begin
                m_cnt = m_cnt + 1;
            end
            if (wr_en) begin
                case (wr_sel)
                    2'd0: m_pre = int'(wr_data[5:0]);
                    2'd1: begin m_duty = int'(wr_data[9:0]); m_full = wr_data[10]; end
                    2'd2: m_per = int'(wr_data[9:0]);
                    default: ;
                endcase
            end
        end
    end

    function automatic bit expected();
        return w_full || (m_cnt < w_duty);
    endfunction

    // Compare the pin with the model on every falling edge
    always @(negedge clk) begin
        if (running && rst_n) begin
            checks++;
            if (pwm_out !== expected()) begin
                fails++;
                $display("FAIL %s: pwm_out=%0b expected %0b at %0t", phase, pwm_out, expected(), $time);
            end
        end
    end

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_pin(input string tag, input logic exp);
        checks++;
        if (pwm_out !== exp) begin
            fails++;
            $display("FAIL %s: pwm_out=%0b expected %0b at %0t", tag, pwm_out, exp, $time);
        end
    endtask

    // Count high clocks over a window and compare with an expected total
    task automatic check_high(input string tag, input int n, input int exp);
        int hi = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out === 1'b1) hi++;
        end
        checks++;
        if (hi != exp) begin
            fails++;
            $display("FAIL %s: high clocks=%0d expected %0d", tag, hi, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        run(4);
        check_pin("R1 reset", 1'b0);
        rst_n = 1'b1;
        running = 1'b1;
        phase = "R1";
        run(5);
        check_pin("R1 idle after reset", 1'b0);

        // R5: basic duty 3 of period 9 at full clock rate
        phase = "R5";
        wr(2'd2, 32'd9);
        wr(2'd1, 32'd3);
        run(25);
        check_high("R5 duty 3 of 10", 30, 9);

        // R2: select 3 and upper data bits are ignored
        phase = "R2";
        wr(2'd3, 32'hFFFF_FFFF);
        wr(2'd2, 32'hFFFF_F809);
        run(40);
        check_high("R2 ignored write", 30, 9);

        // R4: other periods
        phase = "R4";
        wr(2'd2, 32'd4);
        wr(2'd1, 32'd2);
        run(30);
        check_high("R4 period 5", 25, 10);

        // R9: duty beyond the period
        phase = "R9";
        wr(2'd1, 32'd15);
        run(20);
        check_high("R9 duty over period", 20, 20);

        // R6: forced full ignores duty
        phase = "R6";
        wr(2'd1, 32'h0000_0402);
        run(20);
        check_high("R6 forced full", 20, 20);

        // R7: zero duty, non-zero then zero period
        phase = "R7";
        wr(2'd1, 32'd0);
        run(20);
        check_high("R7 zero duty", 20, 0);
        wr(2'd2, 32'd0);
        run(20);
        check_high("R7 zero duty zero period", 20, 0);

        // R8: zero period with non-zero duty or forced full
        phase = "R8";
        wr(2'd1, 32'd5);
        run(10);
        check_high("R8 zero period", 20, 20);
        wr(2'd1, 32'h0000_0400);
        run(10);
        check_high("R8 zero period forced", 20, 20);

        // R3: prescale extremes 64 and 1 clocks per tick
        phase = "R3";
        wr(2'd1, 32'd1);
        wr(2'd2, 32'd2);
        wr(2'd0, 32'd63);
        run(400);
        check_high("R3 prescale 64", 192, 64);
        wr(2'd0, 32'd0);
        run(400);
        check_high("R3 prescale 1", 30, 10);

        // R10: mid-cycle writes wait for the cycle boundary
        phase = "R10";
        wr(2'd2, 32'd99);
        wr(2'd1, 32'd50);
        run(300);
        run(20);
        wr(2'd1, 32'd0);
        wr(2'd2, 32'd3);
        check_pin("R10 mid-cycle write held off", expected());
        run(300);
        wr(2'd1, 32'h0000_0400);
        run(50);

        running = 1'b0;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule